// File: doc/BRIEF.md
# Presettable Up/Down Counter Stage

This block is a four-bit counter stage that steps once per rising clock edge, upward or downward as a direction input selects. A compile-time parameter chooses between a decade sequence (BCD values 0 through 9) and a full binary sequence (0 through 15). An active-low load input copies four data inputs into the count register at once, whether or not the clock is running, and takes priority over every other control.

Each stage gives a terminal-count flag that marks the last state before a wrap in the current direction. It also gives an active-low ripple clock that pulses once for each wrap while counting is enabled. Long counters are built by feeding each stage's ripple clock into the clock of the next stage. A synchronous active-low reset clears the register.

Top module: `updown_counter`

## Requirements
- R1: The count register changes only on a rising edge of `clk` or through the load input; between clock edges, with `load_n` high, `q` holds its value.
- R2: While `load_n` is low, `q` equals `din` at once, without waiting for a clock, and stays there across clock edges; load wins over reset and over counting.
- R3: With `en_n` high and `load_n` high, a rising clock edge leaves `q` unchanged.
- R4: With `dn` low the stage counts up, and with `dn` high it counts down; in binary mode it wraps 15 to 0 going up and 0 to 15 going down.
- R5: In decade mode the stage wraps 9 to 0 going up and 0 to 9 going down; from any of the states 10 to 15 one enabled step goes to 0 when counting up and to 9 when counting down.
- R6: `tc` is high exactly when `dn` is low and `q` is the top value (9 in decade mode, 15 in binary mode), or when `dn` is high and `q` is 0; it follows `q` and `dn` without a clock and does not depend on `en_n`.
- R7: `rc_n` is low only while `en_n` is low, `tc` is high and `clk` is low; in all other cases it is high, so it rises together with the clock edge that makes the wrap.
- R8: When `rst_n` is low at a rising clock edge and `load_n` is high, `q` becomes 0.
- R9: When a stage's `rc_n` drives the `clk` of a second stage whose `en_n` is low, the pair counts as a two-digit counter (0 to 99 in decade mode, 0 to 255 in binary mode) in both directions and wraps at both ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; the state steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Asynchronous active-low load of `din` |
| din | input | 4 | Preset value |
| en_n | input | 1 | Active-low count enable (carry/borrow in from a lower stage) |
| dn | input | 1 | Direction: 0 counts up, 1 counts down |
| q | output | 4 | Current count |
| tc | output | 1 | Terminal count for the selected direction |
| rc_n | output | 1 | Active-low ripple clock for the next stage |

## Verification
A wrong internal state shows at `q` right after the edge that made it, and `tc` shows it at the same moment when the bad value is a terminal one. A wrong next-state rule, most of all at the wraps or when leaving the states 10 to 15 in decade mode, shows one clock later. A fault in the ripple clock shows up in the cascaded pair: the upper digit is off by one at the first wrap of the lower digit, no more than ten or sixteen clocks into a run. The loads applied in the middle of a count check that the asynchronous path moves both digits without the clock.

// File: rtl/udc_pkg.sv
// Shared constants for the up/down counter stage.
// Assumes a four-bit stage; decade mode relies on that width.
package udc_pkg;
    localparam int UDC_W    = 4;
    localparam int DEC_LAST = 9;
endpackage

// File: rtl/udc_next.sv
// Next-state logic of the counter stage.
// Works out the value one enabled step away from q in the direction dn.
// Assumes W >= 4 when DECADE is set; decade mode folds the states above 9
// back into the valid sequence in a single step.
module udc_next #(
    parameter int W      = udc_pkg::UDC_W,
    parameter bit DECADE = 1'b1
) (
    input  logic [W-1:0] q,
    input  logic         dn,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] LAST = W'(udc_pkg::DEC_LAST);

    generate
        if (DECADE) begin : g_decade
            // Decade step: wrap at 9/0 and send out-of-range states to 0 or 9.
            always_comb begin
                if (!dn) begin
                    nxt = (q >= LAST) ? '0 : q + 1'b1;
                end else begin
                    nxt = ((q == '0) || (q > LAST)) ? LAST : q - 1'b1;
                end
            end
        end else begin : g_binary
            // Binary step: natural modulo-2^W wrap in both directions.
            always_comb begin
                nxt = dn ? q - 1'b1 : q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/udc_tc.sv
// Terminal-count decode.
// High at the top value when counting up, at zero when counting down.
// Purely combinational; the enable has no part in it.
module udc_tc #(
    parameter int            W   = udc_pkg::UDC_W,
    parameter logic [W-1:0]  TOP = '1
) (
    input  logic [W-1:0] q,
    input  logic         dn,
    output logic         tc
);
    // Pick the end state that belongs to the current direction.
    always_comb begin
        tc = dn ? (q == '0) : (q == TOP);
    end
endmodule

// File: rtl/updown_counter.sv
// Presettable up/down counter stage with terminal count and ripple clock.
// Holds the count register; the asynchronous load has priority, then the
// synchronous reset, then the enabled count step. Assumes clk is free of
// glitches and that din is stable while load_n is low.
module updown_counter #(
    parameter bit MOD_DECADE = 1'b1,
    parameter int W          = udc_pkg::UDC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_n,
    input  logic         dn,
    output logic [W-1:0] q,
    output logic         tc,
    output logic         rc_n
);
    localparam logic [W-1:0] TOP_VAL = MOD_DECADE ? W'(udc_pkg::DEC_LAST) : {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic         tc_int;

    udc_next #(.W(W), .DECADE(MOD_DECADE)) u_next (
        .q   (cnt_q),
        .dn  (dn),
        .nxt (cnt_nxt)
    );

    udc_tc #(.W(W), .TOP(TOP_VAL)) u_tc (
        .q  (cnt_q),
        .dn (dn),
        .tc (tc_int)
    );

    // Count register: asynchronous load, then synchronous clear, then step.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            cnt_q <= din;
        end else if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_n) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Ripple clock: low during the clock's low phase of an enabled wrap.
    always_comb begin
        rc_n = ~(~en_n & tc_int & ~clk);
    end

    assign q  = cnt_q;
    assign tc = tc_int;

    // R2: a load held across an edge keeps the preset value in the register.
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |-> (cnt_q == din));

    // R6: a raised terminal flag always matches the end state of the direction.
    a_r6_tc_match: assert property (@(negedge clk) disable iff (!rst_n)
        (tc_int === 1'b1) |-> (dn ? (cnt_q == '0) : (cnt_q == TOP_VAL)));

    // R7: a low ripple clock seen just before an edge needs an enabled terminal state.
    a_r7_rc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_n === 1'b0) |-> (tc_int && !en_n));

    generate
        if (MOD_DECADE) begin : g_dec_chk
            // R5: from any known state the next step lands inside 0..9.
            a_r5_next_valid: assert property (@(negedge clk) disable iff (!rst_n)
                (!$isunknown(cnt_q)) |-> (cnt_nxt <= TOP_VAL));
        end
    endgenerate
endmodule

// File: tb/sim_updown_counter.sv
`timescale 1ns/1ps
module sim_updown_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld0 = 1'b1, ld1 = 1'b1, ld2 = 1'b1, ld3 = 1'b1;
    logic [3:0] din0 = '0, din1 = '0, din2 = '0, din3 = '0;
    logic en_d = 1'b0, en_b = 1'b0;
    logic dn_d = 1'b0, dn_b = 1'b0;
    logic [3:0] q0, q1, q2, q3;
    logic tc0, tc1, tc2, tc3;
    logic rc0, rc1, rc2, rc3;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // Decade pair: u0 is the low digit, u1 the high digit.
    updown_counter #(.MOD_DECADE(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .load_n(ld0),
        .din(din0), .en_n(en_d), .dn(dn_d), .q(q0), .tc(tc0), .rc_n(rc0));
    updown_counter #(.MOD_DECADE(1'b1)) u1 (.clk(rc0), .rst_n(rst_n), .load_n(ld1),
        .din(din1), .en_n(1'b0), .dn(dn_d), .q(q1), .tc(tc1), .rc_n(rc1));
    // Binary pair: u2 low nibble, u3 high nibble.
    updown_counter #(.MOD_DECADE(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .load_n(ld2),
        .din(din2), .en_n(en_b), .dn(dn_b), .q(q2), .tc(tc2), .rc_n(rc2));
    updown_counter #(.MOD_DECADE(1'b0)) u3 (.clk(rc2), .rst_n(rst_n), .load_n(ld3),
        .din(din3), .en_n(1'b0), .dn(dn_b), .q(q3), .tc(tc3), .rc_n(rc3));

    // Vector: [11] load, [10:7] din, [6] en_n, [5] dn, [4:1] expected q, [0] expected tc
    localparam int NV = 17;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b0},
        {1'b1, 4'd8,  1'b0, 1'b0, 4'd8,  1'b0},
        {1'b0, 4'd0,  1'b0, 1'b0, 4'd9,  1'b1},
        {1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
        {1'b0, 4'd0,  1'b0, 1'b1, 4'd9,  1'b0},
        {1'b0, 4'd0,  1'b1, 1'b1, 4'd9,  1'b0},
        {1'b1, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1},
        {1'b0, 4'd0,  1'b0, 1'b1, 4'd9,  1'b0},
        {1'b1, 4'd12, 1'b0, 1'b0, 4'd12, 1'b0},
        {1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
        {1'b1, 4'd15, 1'b0, 1'b1, 4'd15, 1'b0},
        {1'b0, 4'd0,  1'b0, 1'b1, 4'd9,  1'b0},
        {1'b1, 4'd10, 1'b1, 1'b0, 4'd10, 1'b0},
        {1'b0, 4'd0,  1'b1, 1'b0, 4'd10, 1'b0},
        {1'b0, 4'd0,  1'b0, 1'b1, 4'd9,  1'b0},
        {1'b1, 4'd9,  1'b1, 1'b0, 4'd9,  1'b1},
        {1'b0, 4'd0,  1'b1, 1'b0, 4'd9,  1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int dec_val();
        return int'(q1) * 10 + int'(q0);
    endfunction

    function automatic int bin_val();
        return int'(q3) * 16 + int'(q2);
    endfunction

    // Load both decade digits while clk is high, so the ripple clock stays quiet.
    task automatic load_dec(input int v);
        @(posedge clk);
        #0.5;
        din0 = 4'(v % 10); din1 = 4'(v / 10);
        ld0 = 1'b0; ld1 = 1'b0;
        #0.5;
        chk("R2 decade pair async load", dec_val(), v);
        ld0 = 1'b1; ld1 = 1'b1;
    endtask

    task automatic load_bin(input int v);
        @(posedge clk);
        #0.5;
        din2 = 4'(v % 16); din3 = 4'(v / 16);
        ld2 = 1'b0; ld3 = 1'b0;
        #0.5;
        chk("R2 binary pair async load", bin_val(), v);
        ld2 = 1'b1; ld3 = 1'b1;
    endtask

    // Direction changes also happen while clk is high.
    task automatic set_dir(input logic d);
        @(posedge clk);
        #0.5;
        dn_d = d; dn_b = d;
    endtask

    task automatic run_dec(input int start, input int steps, input logic down);
        for (int k = 1; k <= steps; k++) begin
            @(posedge clk);
            #0.5;
            chk("R9 decade cascade", dec_val(),
                down ? ((start - k) % 100 + 100) % 100 : (start + k) % 100);
        end
    endtask

    task automatic run_bin(input int start, input int steps, input logic down);
        for (int k = 1; k <= steps; k++) begin
            @(posedge clk);
            #0.5;
            chk("R9 R4 binary cascade", bin_val(),
                down ? ((start - k) % 256 + 256) % 256 : (start + k) % 256);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: synchronous clear.
        @(posedge clk);
        @(posedge clk);
        #0.5;
        chk("R8 reset clears decade stage", int'(q0), 0);
        chk("R8 reset clears binary stage", int'(q2), 0);
        chk("R6 tc after reset counting up", int'(tc0), 0);
        rst_n = 1'b1;

        // Table walk on the decade low stage.
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            @(negedge clk);
            #0.5;
            en_d = v[6];
            dn_d = v[5];
            if (v[11]) begin
                din0 = v[10:7];
                ld0 = 1'b0;
                #0.5;
                chk("R2 load without clock", int'(q0), int'(v[4:1]));
                chk("R6 tc after load", int'(tc0), int'(v[0]));
                @(posedge clk);
                #0.5;
                chk("R2 load held over edge", int'(q0), int'(v[4:1]));
                ld0 = 1'b1;
            end else begin
                @(posedge clk);
                #0.5;
                chk(v[6] ? "R3 hold when disabled" : "R5 decade step", int'(q0), int'(v[4:1]));
                chk("R6 tc after step", int'(tc0), int'(v[0]));
            end
        end

        // R1: no change between edges.
        @(negedge clk);
        #0.5;
        en_d = 1'b0; dn_d = 1'b0;
        @(posedge clk);
        #0.5;
        chk("R1 step on rising edge", int'(q0), 0);
        @(negedge clk);
        #1.0;
        chk("R1 no change on falling edge", int'(q0), 0);

        // R2 over R8: load beats reset.
        @(negedge clk);
        #0.5;
        rst_n = 1'b0; din0 = 4'd6; ld0 = 1'b0;
        @(posedge clk);
        #0.5;
        chk("R2 load beats reset", int'(q0), 6);
        ld0 = 1'b1;
        @(posedge clk);
        #0.5;
        chk("R8 reset after load released", int'(q0), 0);
        rst_n = 1'b1;

        // R7 and R6: ripple clock gating.
        @(posedge clk);
        #0.5;
        en_d = 1'b0; dn_d = 1'b0; din0 = 4'd9; ld0 = 1'b0;
        #0.5;
        ld0 = 1'b1;
        chk("R7 rc high while clk high", int'(rc0), 1);
        @(negedge clk);
        #0.5;
        chk("R7 rc low at enabled terminal", int'(rc0), 0);
        en_d = 1'b1;
        #0.2;
        chk("R7 rc high when disabled", int'(rc0), 1);
        chk("R6 tc ignores enable", int'(tc0), 1);
        en_d = 1'b0;
        #0.2;
        chk("R7 rc low again", int'(rc0), 0);
        @(posedge clk);
        #0.5;
        chk("R7 rc rises with wrap edge", int'(rc0), 1);
        chk("R5 wrap 9 to 0", int'(q0), 0);

        // R9: decade cascade both directions with a mid-count load.
        set_dir(1'b0);
        load_dec(0);
        run_dec(0, 105, 1'b0);
        load_dec(75);
        run_dec(75, 30, 1'b0);
        set_dir(1'b1);
        load_dec(5);
        run_dec(5, 105, 1'b1);
        load_dec(42);
        run_dec(42, 50, 1'b1);

        // R9 and R4: binary cascade both directions with a mid-count load.
        set_dir(1'b0);
        load_bin(0);
        run_bin(0, 260, 1'b0);
        load_bin(240);
        run_bin(240, 20, 1'b0);
        set_dir(1'b1);
        load_bin(4);
        run_bin(4, 260, 1'b1);
        load_bin(130);
        run_bin(130, 40, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule